// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that completes one instruction on every rising clock edge. Each instruction is fetched from an internal program store, decoded by a separate control decoder, run through a shared ALU and retired in the same cycle. The supported set covers six register-to-register operations, a word load, a word store, a branch-if-equal and an unconditional jump.

The core holds its own 64-word program store and 64-word data store. Both are filled from built-in contents whenever reset is applied. The only inputs are a clock and a synchronous active-high reset. The outputs show every data-memory write as it happens: the store strobe, the byte address and the word being written. The core is meant to be dropped into a larger system as a self-running test engine, or watched by a bench that follows its store trace.

The built-in program does the following:

- loads four constants;
- stores the result of each ALU operation;
- writes to register 0 and stores that register;
- reads back an earlier store;
- stores through a negative offset;
- takes and skips a forward branch;
- runs a three-pass counting loop closed by a backward jump;
- jumps over one store;
- parks on a branch to itself.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `st_we` is 0. On the first edge with `rst` high, the program counter goes to 0, every register is cleared and the data store is reloaded. After `rst` falls, execution restarts at word 0, so the store trace repeats from its first entry.
- R2: An instruction with opcode 0 is a register operation. Its function field selects the operation and the 4-bit ALU code it uses: 0x24 AND (0000), 0x25 OR (0001), 0x20 ADD (0010), 0x22 SUB (0110), 0x2A set-if-less-than (0111, signed, result 1 or 0), 0x27 NOR (1100).
- R3: The register file reads the registers named in bits [25:21] and [20:16] at the same time. A register operation writes the register named in bits [15:11], and a load writes the one in bits [20:16]. Register 0 reads as zero and ignores writes.
- R4: Load (opcode 0x23) and store (opcode 0x2B) form the address as base register plus the sign-extended 16-bit offset, using the ALU add code. A store drives `st_we`=1, `st_addr` and `st_data` in the cycle it executes and commits at that cycle's closing edge. A later load of the same word returns the stored value.
- R5: Branch-if-equal (opcode 0x04) compares its two registers with an ALU subtraction. When the zero flag is set, the next PC is PC+4 plus the sign-extended offset shifted left by two. Otherwise execution falls through to PC+4.
- R6: Jump (opcode 0x02) loads the next PC with bits [31:28] of PC+4 followed by the 26-bit index and two zero bits.
- R7: Exactly one instruction retires per clock. With no taken branch or jump, the PC advances by 4, and it is always word aligned.
- R8: Both stores hold 64 words and select a word by address bits [7:2]. The program and data reads are combinational, and data writes happen on the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| st_data | output | 32 | Word driven toward the data store (second read register) |
| st_addr | output | 32 | Byte address computed by the ALU |
| st_we | output | 1 | Data-store write strobe, high for the cycle of a store |

## Verification
Every result of this core shows up in the same cycle as the store that exposes it. The three outputs are combinational from the current PC, so a store retiring at cycle n after reset release is visible before the edge that ends cycle n. The bench counts cycles from the release of reset and compares each strobe against the cycle number, address and data it has computed. It samples one nanosecond after each falling edge, half a period away from any register update. The bench also applies reset at random points mid-program. It checks that the strobe stays low during reset and that the trace restarts from its first store.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
    localparam int XLEN      = 32;
    localparam int REG_AW    = 5;
    localparam int MEM_WORDS = 64;
    localparam int MEM_AW    = $clog2(MEM_WORDS);

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [5:0] {
        OP_REG   = 6'h00,
        OP_JUMP  = 6'h02,
        OP_BEQ   = 6'h04,
        OP_LOAD  = 6'h23,
        OP_STORE = 6'h2B
    } opcode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    src_imm;
        logic    mem_to_reg;
        logic    mem_we;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [31:0] enc_r(logic [5:0] fn, int rs, int rt, int rd);
        return {OP_REG, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(opcode_e op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(int word_idx);
        return {OP_JUMP, 26'(word_idx)};
    endfunction

    // Built-in program; every unlisted word parks on a branch to itself.
    function automatic logic [31:0] prog_word(int idx);
        logic [31:0] w;
        case (idx)
            0:  w = enc_i(OP_LOAD, 0, 1, 0);
            1:  w = enc_i(OP_LOAD, 0, 2, 4);
            2:  w = enc_i(OP_LOAD, 0, 3, 8);
            3:  w = enc_i(OP_LOAD, 0, 4, 12);
            4:  w = enc_r(FN_ADD, 1, 2, 5);
            5:  w = enc_i(OP_STORE, 0, 5, 64);
            6:  w = enc_r(FN_SUB, 1, 2, 6);
            7:  w = enc_i(OP_STORE, 0, 6, 68);
            8:  w = enc_r(FN_AND, 3, 4, 7);
            9:  w = enc_i(OP_STORE, 0, 7, 72);
            10: w = enc_r(FN_OR, 3, 4, 8);
            11: w = enc_i(OP_STORE, 0, 8, 76);
            12: w = enc_r(FN_NOR, 3, 4, 9);
            13: w = enc_i(OP_STORE, 0, 9, 80);
            14: w = enc_r(FN_SLT, 2, 1, 10);
            15: w = enc_r(FN_SLT, 1, 2, 11);
            16: w = enc_i(OP_STORE, 0, 10, 84);
            17: w = enc_i(OP_STORE, 0, 11, 88);
            18: w = enc_r(FN_ADD, 1, 1, 0);
            19: w = enc_i(OP_STORE, 0, 0, 92);
            20: w = enc_i(OP_LOAD, 0, 12, 64);
            21: w = enc_i(OP_STORE, 0, 12, 96);
            22: w = enc_r(FN_ADD, 6, 6, 13);
            23: w = enc_i(OP_STORE, 13, 1, -4);
            24: w = enc_i(OP_BEQ, 1, 2, 5);
            25: w = enc_i(OP_STORE, 0, 2, 100);
            26: w = enc_i(OP_BEQ, 10, 10, 1);
            27: w = enc_i(OP_STORE, 0, 3, 104);
            28: w = enc_i(OP_STORE, 0, 4, 108);
            29: w = enc_r(FN_ADD, 10, 10, 17);
            30: w = enc_r(FN_ADD, 17, 10, 17);
            31: w = enc_r(FN_ADD, 14, 10, 14);
            32: w = enc_i(OP_STORE, 0, 14, 112);
            33: w = enc_i(OP_BEQ, 14, 17, 1);
            34: w = enc_j(31);
            35: w = enc_j(37);
            36: w = enc_i(OP_STORE, 0, 3, 116);
            37: w = enc_i(OP_STORE, 0, 17, 120);
            default: w = enc_i(OP_BEQ, 0, 0, -1);
        endcase
        return w;
    endfunction

    function automatic logic [31:0] data_init(int idx);
        logic [31:0] w;
        case (idx)
            0:  w = 32'h0000_0005;
            1:  w = 32'hFFFF_FFF3;
            2:  w = 32'h0F0F_00FF;
            3:  w = 32'h1234_5678;
            default: w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);
    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_REG: begin
                ctl.reg_we = 1'b1;
                ctl.dst_rd = 1'b1;
                unique case (funct)
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    FN_NOR:  ctl.alu_op = ALU_NOR;
                    default: ctl.reg_we = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctl.reg_we     = 1'b1;
                ctl.src_imm    = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            OP_STORE: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            OP_JUMP: ctl.jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rsel_a,
    input  logic [AW-1:0] rsel_b,
    input  logic [AW-1:0] wsel,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wsel != '0)) begin
            regs[wsel] <= wdata;
        end
    end

    assign rdata_a = regs[rsel_a];
    assign rdata_b = regs[rsel_b];

    // R3
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (rsel_a == '0) |-> (rdata_a == '0));

    // R3
    reg_land_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (wsel != '0)) |=> (regs[$past(wsel)] == $past(wdata)));
endmodule

// File: rtl/sc_dmem.sv
`timescale 1ns/1ps
module sc_dmem
    import sc_pkg::*;
#(
    parameter int DW    = XLEN,
    parameter int WORDS = MEM_WORDS,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= DW'(data_init(i));
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[widx];

    // R4
    store_land_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] st_data,
    output logic [31:0] st_addr,
    output logic        st_we
);
    logic [XLEN-1:0]   pc, pc_next, pc_plus4, instr;
    logic [XLEN-1:0]   imm_ext, br_target, jmp_target;
    logic [XLEN-1:0]   rd_a, rd_b, alu_b, alu_y, ld_word, wb_data;
    logic [REG_AW-1:0] wsel;
    logic              alu_zero, br_taken, dm_we;
    ctrl_t             ctl;

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign instr = prog_word(int'(pc[MEM_AW+1:2]));

    sc_ctrl ctrl_i (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    assign wsel    = ctl.dst_rd ? instr[15:11] : instr[20:16];
    assign wb_data = ctl.mem_to_reg ? ld_word : alu_y;

    sc_regfile #(.DW(XLEN), .AW(REG_AW)) rf_i (
        .clk     (clk),
        .rst     (rst),
        .rsel_a  (instr[25:21]),
        .rsel_b  (instr[20:16]),
        .wsel    (wsel),
        .we      (ctl.reg_we),
        .wdata   (wb_data),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign alu_b   = ctl.src_imm ? imm_ext : rd_b;

    sc_alu #(.DW(XLEN)) alu_i (
        .a    (rd_a),
        .b    (alu_b),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dm_we = ctl.mem_we & ~rst;

    sc_dmem #(.DW(XLEN), .WORDS(MEM_WORDS)) dm_i (
        .clk   (clk),
        .rst   (rst),
        .we    (dm_we),
        .widx  (alu_y[MEM_AW+1:2]),
        .wdata (rd_b),
        .rdata (ld_word)
    );

    assign pc_plus4   = pc + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign br_taken   = ctl.branch & alu_zero;
    assign pc_next    = ctl.jump ? jmp_target : (br_taken ? br_target : pc_plus4);

    assign st_data = rd_b;
    assign st_addr = alu_y;
    assign st_we   = dm_we;

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.jump || (ctl.branch && (rd_a == rd_b))) |=> (pc == $past(pc) + 32'd4));

    // R5
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.branch && (rd_a == rd_b)) |=>
        (pc == $past(pc) + 32'd4 + ($past(imm_ext) << 2)));

    // R7
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |-> !st_we);
endmodule

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] st_data, st_addr;
    logic        st_we;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    localparam int NST      = 16;
    localparam int RUN_CYC  = 60;
    localparam logic [31:0] VA = 32'h0000_0005;
    localparam logic [31:0] VB = 32'hFFFF_FFF3;
    localparam logic [31:0] VC = 32'h0F0F_00FF;
    localparam logic [31:0] VD = 32'h1234_5678;

    always #4 clk = ~clk;

    sc_core dut_i (
        .clk     (clk),
        .rst     (rst),
        .st_data (st_data),
        .st_addr (st_addr),
        .st_we   (st_we)
    );

    function automatic int exp_cyc(int k);
        int t [NST] = '{5, 7, 9, 11, 13, 16, 17, 19, 21, 23, 25, 27, 31, 35, 39, 42};
        return t[k];
    endfunction

    function automatic logic [31:0] exp_addr(int k);
        logic [31:0] t [NST] = '{32'h40, 32'h44, 32'h48, 32'h4C, 32'h50, 32'h54, 32'h58,
                                 32'h5C, 32'h60, 32'h20, 32'h64, 32'h6C, 32'h70, 32'h70,
                                 32'h70, 32'h78};
        return t[k];
    endfunction

    function automatic logic [31:0] exp_data(int k);
        case (k)
            0:  return VA + VB;                                   // R2 add
            1:  return VA - VB;                                   // R2 sub
            2:  return VC & VD;                                   // R2 and
            3:  return VC | VD;                                   // R2 or
            4:  return ~(VC | VD);                                // R2 nor
            5:  return ($signed(VB) < $signed(VA)) ? 32'd1 : 32'd0; // R2 slt true
            6:  return ($signed(VA) < $signed(VB)) ? 32'd1 : 32'd0; // R2 slt false
            7:  return 32'd0;                                     // R3 register 0
            8:  return VA + VB;                                   // R4/R8 readback
            9:  return VA;                                        // R4 negative offset
            10: return VB;                                        // R5 fall-through
            11: return VD;                                        // R5 taken
            12: return 32'd1;
            13: return 32'd2;
            14: return 32'd3;
            default: return 32'd3;                                // R6 after jump
        endcase
    endfunction

    function automatic string exp_req(int k);
        case (k)
            0, 1, 2, 3, 4, 5, 6: return "R2";
            7:  return "R3";
            8:  return "R4 R8";
            9:  return "R4";
            10, 11: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reset pulse; returns one ns after release, at cycle 0 of a run.
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk(st_we == 1'b0, "R1", "strobe during reset", 32'(st_we), 32'd0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(st_addr == 32'd0 && !st_we, "R1", "first fetch address after reset", st_addr, 32'd0);
    endtask

    // Follows the store trace for up to ncyc cycles; full runs check completion.
    task automatic run_prog(int ncyc, bit full);
        int k = 0;
        int stray = 0;
        for (int c = 0; c < ncyc; c++) begin
            if (st_we) begin
                if (k < NST) begin
                    chk(c == exp_cyc(k), "R7", $sformatf("cycle of store %0d", k), 32'(c), 32'(exp_cyc(k)));
                    chk(st_addr == exp_addr(k), exp_req(k), $sformatf("address of store %0d", k), st_addr, exp_addr(k));
                    chk(st_data == exp_data(k), exp_req(k), $sformatf("data of store %0d", k), st_data, exp_data(k));
                    k++;
                end else begin
                    stray++;
                end
            end else if (k < NST && c == exp_cyc(k)) begin
                chk(1'b0, "R7", $sformatf("missing store %0d", k), 32'(c), 32'(exp_cyc(k)));
                k++;
            end
            @(negedge clk);
            #1;
        end
        if (full) begin
            chk(k == NST, "R7", "stores seen in run", 32'(k), 32'(NST));
            chk(stray == 0, "R5 R6", "stores after halt or skipped stores", 32'(stray), 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (2) @(negedge clk);
        do_reset();
        run_prog(RUN_CYC, 1'b1);
        for (int r = 0; r < 4; r++) begin
            int stop_at = 1 + int'($urandom % 42);
            do_reset();
            run_prog(stop_at, 1'b0);
            do_reset();                         // R1 restart from word 0
            run_prog(RUN_CYC, 1'b1);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule